// File: doc/BRIEF.md
# Consist Slot Chain Resolver

The block keeps a table of 128 locomotive slots. Each slot holds a 7-bit speed field, a direction bit, two consist-role bits (linked up, linked down) and a two-bit activity state. When a slot is linked upward into a consist, its speed field stops holding a speed and holds the number of the next slot up instead. A consist can itself be linked into a larger one, so the slot that sets the motion of any given slot can lie several links away.

A client sends one request at a time and gets one response back. A resolve request follows the chain of upward links from the given slot until it reaches a slot that is not linked upward. It then returns that slot's speed, direction and activity state, which apply to every member below it. Three write requests maintain the table. A store sets a slot's speed, direction and state. A link joins a member below a target slot. An unlink detaches a member again. A chain that runs too long, or that reaches a slot holding no valid data, ends in an error response. Speed codes pass through unchanged: 0x00 is stop, 0x01 is emergency stop, and 0x02 to 0x7F are rising speeds.

Top module: `consist_resolver`

## Requirements
- R1: After reset every slot is free (speed 0, direction 0, not linked, state 00). `busy` and `rsp_valid` are low, and a resolve of any slot returns speed 0, direction 0, state 00 with no error.
- R2: `req_op` selects the operation: 0 resolve, 1 store, 2 link, 3 unlink. A request is taken on a rising edge where `req_valid` is high and `busy` is low. A request presented while `busy` is high is ignored and leaves the table unchanged.
- R3: A resolve of a slot that is not linked upward returns that slot's own speed, direction and state. The one-cycle `rsp_valid` pulse comes h+1 edges after the accepting edge, where h is the number of links followed (here 0).
- R4: A resolve of a linked slot follows pointers through any number of levels. It returns the speed, direction and state of the first slot reached that is not linked upward, with the latency of R3.
- R5: `busy` rises on the edge that accepts a resolve, stays high until the response edge, and is low in the cycle where `rsp_valid` is high. Write requests never raise `busy`, and they respond on the edge after acceptance.
- R6: A store writes speed, direction and state into a slot that is not linked upward. A store to an up-linked slot gives an error and changes nothing.
- R7: A link of member m to target t writes t into m's speed field and marks m linked up and t linked down. The link is refused with an error, and nothing changes, if m is already linked up, if m equals t, or if t has state 00.
- R8: An unlink of member m clears its up-link, sets its speed to 0x00 and clears the down mark of the slot it pointed to. Afterwards m resolves to its own direction and state. An unlink of a slot that is not linked up gives an error and changes nothing.
- R9: A resolve that is still on an up-linked slot after 128 links have been followed ends with an error.
- R10: A resolve that meets a pointer to a slot with state 00 ends with an error.
- R11: Every response with `rsp_err` high, and every write response, carries speed 0, direction 0 and state 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation code (R2) |
| req_slot | input | 7 | Slot to resolve, store to, or the member for link and unlink |
| req_arg | input | 7 | Target slot for a link |
| req_spd | input | 7 | Speed written by a store |
| req_dir | input | 1 | Direction written by a store |
| req_state | input | 2 | Activity state written by a store |
| busy | output | 1 | A resolve is in progress; new requests are ignored |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request refused or chain broken |
| rsp_spd | output | 7 | Resolved speed |
| rsp_dir | output | 1 | Resolved direction |
| rsp_state | output | 2 | Resolved activity state |

## Verification
The assertions assume that `req_op` carries one of the four codes, and that `req_valid` is low while reset is asserted. The stimulus holds `req_valid` low during reset. It changes request inputs only at falling edges and uses only the defined opcodes. It deliberately presents one request while `busy` is high, to confirm that the design ignores it. It builds deep chains, a closed loop and a pointer into a freed slot. These cover the longest resolve, which lasts 129 busy cycles, within the bound the checker enforces.

// File: rtl/cr_pkg.sv
// Shared widths, slot record layout and operation codes for the resolver.
package cr_pkg;
    localparam int SLOT_W = 7;
    localparam int NSLOT  = 1 << SLOT_W;
    localparam int HOP_W  = SLOT_W + 1;

    typedef struct packed {
        logic [SLOT_W-1:0] spd;   // speed, or next slot number when up is set
        logic              dir;
        logic              up;    // linked upward
        logic              dn;    // linked downward
        logic [1:0]        st;    // activity state, 00 = free
    } slot_rec_t;

    typedef enum logic [1:0] {
        OP_RESOLVE = 2'd0,
        OP_STORE   = 2'd1,
        OP_LINK    = 2'd2,
        OP_UNLINK  = 2'd3
    } cr_op_e;
endpackage

// File: rtl/cr_slot_table.sv
// Slot record storage: two asynchronous read ports and two write ports.
// Assumes the writer never drives both write ports at one index; port B
// takes precedence if it does.
module cr_slot_table
    import cr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_a,
    input  logic [SLOT_W-1:0] wa_idx,
    input  slot_rec_t         wa_rec,
    input  logic              we_b,
    input  logic [SLOT_W-1:0] wb_idx,
    input  slot_rec_t         wb_rec,
    input  logic [SLOT_W-1:0] ra_idx,
    output slot_rec_t         ra_rec,
    input  logic [SLOT_W-1:0] rb_idx,
    output slot_rec_t         rb_rec
);
    slot_rec_t mem [NSLOT];

    // Clear every record on reset, otherwise apply the enabled writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) mem[i] <= '0;
        end else begin
            if (we_a) mem[wa_idx] <= wa_rec;
            if (we_b) mem[wb_idx] <= wb_rec;
        end
    end

    // Read ports.
    always_comb begin
        ra_rec = mem[ra_idx];
        rb_rec = mem[rb_idx];
    end
endmodule

// File: rtl/cr_linker.sv
// Decodes store, link and unlink requests into table writes and an error
// flag. Purely combinational. Assumes m_rec is the record at req_slot and
// t_rec the record at the target (req_arg for link, m_rec.spd for unlink).
module cr_linker
    import cr_pkg::*;
(
    input  logic              accept,
    input  cr_op_e            op,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SLOT_W-1:0] arg,
    input  logic [SLOT_W-1:0] spd,
    input  logic              dir,
    input  logic [1:0]        st,
    input  slot_rec_t         m_rec,
    input  slot_rec_t         t_rec,
    output logic              we_a,
    output slot_rec_t         wa_rec,
    output logic              we_b,
    output logic [SLOT_W-1:0] wb_idx,
    output slot_rec_t         wb_rec,
    output logic              err
);
    // Build the new member and target records and the refusal conditions.
    always_comb begin
        wa_rec = m_rec;
        wb_rec = t_rec;
        wb_idx = arg;
        err    = 1'b0;
        unique case (op)
            OP_STORE: begin
                err        = m_rec.up;
                wa_rec.spd = spd;
                wa_rec.dir = dir;
                wa_rec.st  = st;
            end
            OP_LINK: begin
                err        = m_rec.up || (slot == arg) || (t_rec.st == 2'b00);
                wa_rec.spd = arg;
                wa_rec.up  = 1'b1;
                wb_rec.dn  = 1'b1;
            end
            OP_UNLINK: begin
                err        = !m_rec.up;
                wa_rec.spd = '0;
                wa_rec.up  = 1'b0;
                wb_idx     = m_rec.spd;
                wb_rec.dn  = 1'b0;
            end
            default: ;
        endcase
        we_a = accept && (op != OP_RESOLVE) && !err;
        we_b = we_a && (op == OP_LINK || op == OP_UNLINK);
    end
endmodule

// File: rtl/cr_walker.sv
// Pointer-chase engine. Starting at a slot, it moves one link per cycle
// until it reaches a slot that is not linked upward. It stops with an error
// if the hop limit is reached or the next slot is free. Assumes the cur_*
// inputs reflect the record at cur_idx and nxt_st the state of the slot
// that record points to, in the same cycle.
module cr_walker
    import cr_pkg::*;
#(
    parameter int MAX_HOPS = NSLOT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SLOT_W-1:0] start_slot,
    input  logic              cur_up,
    input  logic [SLOT_W-1:0] cur_spd,
    input  logic              cur_dir,
    input  logic [1:0]        cur_st,
    input  logic [1:0]        nxt_st,
    output logic [SLOT_W-1:0] cur_idx,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [SLOT_W-1:0] res_spd,
    output logic              res_dir,
    output logic [1:0]        res_st
);
    localparam logic [HOP_W-1:0] HOP_LIM = HOP_W'(MAX_HOPS);

    typedef enum logic {W_IDLE, W_WALK} wstate_e;
    wstate_e          state;
    logic [HOP_W-1:0] hops;
    logic             at_top, stuck;

    // Classify the current step of the walk.
    always_comb begin
        at_top  = !cur_up;
        stuck   = cur_up && ((hops == HOP_LIM) || (nxt_st == 2'b00));
        busy    = (state == W_WALK);
        done    = busy && (at_top || stuck);
        err     = busy && stuck;
        res_spd = cur_spd;
        res_dir = cur_dir;
        res_st  = cur_st;
    end

    // Advance the walk one link per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= W_IDLE;
            hops    <= '0;
            cur_idx <= '0;
        end else if (state == W_IDLE) begin
            if (start) begin
                state   <= W_WALK;
                hops    <= '0;
                cur_idx <= start_slot;
            end
        end else if (done) begin
            state <= W_IDLE;
        end else begin
            cur_idx <= cur_spd;
            hops    <= hops + 1'b1;
        end
    end
endmodule

// File: rtl/consist_resolver.sv
// Top of the consist slot chain resolver. It accepts one request when not
// busy. Writes complete on the next edge; resolves run the walker and
// respond when it finishes. Assumes req_* are stable at the accepting edge.
module consist_resolver
    import cr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [SLOT_W-1:0] req_arg,
    input  logic [SLOT_W-1:0] req_spd,
    input  logic              req_dir,
    input  logic [1:0]        req_state,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [SLOT_W-1:0] rsp_spd,
    output logic              rsp_dir,
    output logic [1:0]        rsp_state
);
    cr_op_e            op;
    logic              accept, wr_accept;
    slot_rec_t         ra_rec, rb_rec, wa_rec, wb_rec;
    logic [SLOT_W-1:0] ra_idx, rb_idx, wb_idx, cur_idx;
    logic              we_a, we_b, lk_err;
    logic              w_busy, w_done, w_err, w_dir;
    logic [SLOT_W-1:0] w_spd;
    logic [1:0]        w_st;

    // Request acceptance and read-port steering.
    always_comb begin
        op        = cr_op_e'(req_op);
        accept    = req_valid && !w_busy;
        wr_accept = accept && (op != OP_RESOLVE);
        ra_idx    = w_busy ? cur_idx : req_slot;
        rb_idx    = (!w_busy && op == OP_LINK) ? req_arg : ra_rec.spd;
        busy      = w_busy;
    end

    cr_slot_table u_tab (
        .clk(clk), .rst_n(rst_n),
        .we_a(we_a), .wa_idx(req_slot), .wa_rec(wa_rec),
        .we_b(we_b), .wb_idx(wb_idx), .wb_rec(wb_rec),
        .ra_idx(ra_idx), .ra_rec(ra_rec),
        .rb_idx(rb_idx), .rb_rec(rb_rec)
    );

    cr_linker u_lnk (
        .accept(accept), .op(op), .slot(req_slot), .arg(req_arg),
        .spd(req_spd), .dir(req_dir), .st(req_state),
        .m_rec(ra_rec), .t_rec(rb_rec),
        .we_a(we_a), .wa_rec(wa_rec),
        .we_b(we_b), .wb_idx(wb_idx), .wb_rec(wb_rec),
        .err(lk_err)
    );

    cr_walker #(.MAX_HOPS(NSLOT)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .start(accept && op == OP_RESOLVE), .start_slot(req_slot),
        .cur_up(ra_rec.up), .cur_spd(ra_rec.spd), .cur_dir(ra_rec.dir),
        .cur_st(ra_rec.st), .nxt_st(rb_rec.st),
        .cur_idx(cur_idx), .busy(w_busy), .done(w_done), .err(w_err),
        .res_spd(w_spd), .res_dir(w_dir), .res_st(w_st)
    );

    // Register the response for writes and for completed resolves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_spd   <= '0;
            rsp_dir   <= 1'b0;
            rsp_state <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (wr_accept) begin
                rsp_valid <= 1'b1;
                rsp_err   <= lk_err;
                rsp_spd   <= '0;
                rsp_dir   <= 1'b0;
                rsp_state <= '0;
            end else if (w_done) begin
                rsp_valid <= 1'b1;
                rsp_err   <= w_err;
                rsp_spd   <= w_err ? '0 : w_spd;
                rsp_dir   <= w_err ? 1'b0 : w_dir;
                rsp_state <= w_err ? 2'b00 : w_st;
            end
        end
    end
endmodule

// File: rtl/cr_checker.sv
// Protocol checker for consist_resolver, attached by bind.
module cr_checker
    import cr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic              busy,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [SLOT_W-1:0] rsp_spd,
    input logic              rsp_dir,
    input logic [1:0]        rsp_state
);
    logic [HOP_W+1:0] busy_cnt;

    // Count consecutive busy cycles to bound the walk length.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cnt <= '0;
        else                 busy_cnt <= busy_cnt + 1'b1;
    end

    // R9: no resolve stays busy longer than the hop limit plus one cycle.
    always_ff @(posedge clk) begin
        if (rst_n) a_r9_walk_bounded: assert (busy_cnt <= (HOP_W+2)'(NSLOT + 1));
    end

    a_r5_busy_ends_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rsp_valid);

    a_r5_no_rsp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);

    a_r5_write_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op != 2'd0) |=> (rsp_valid && !busy));

    a_r3_resolve_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == 2'd0) |=> (busy && !rsp_valid));

    a_r2_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(busy) || $past(req_valid)));

    a_r11_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_spd == '0 && !rsp_dir && rsp_state == 2'b00));
endmodule

bind consist_resolver cr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_spd(rsp_spd), .rsp_dir(rsp_dir), .rsp_state(rsp_state)
);

// File: tb/sim_consist_resolver.sv
`timescale 1ns/1ps
module sim_consist_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [6:0] req_slot = '0, req_arg = '0, req_spd = '0;
    logic       req_dir = 1'b0;
    logic [1:0] req_state = '0;
    logic       busy, rsp_valid, rsp_err, rsp_dir;
    logic [6:0] rsp_spd;
    logic [1:0] rsp_state;

    int total = 0, bad = 0;
    bit finished = 0;

    // Behavioural reference table.
    int m_spd [128];
    bit m_dir [128];
    bit m_up  [128];
    bit m_dn  [128];
    int m_st  [128];

    always #2 clk = ~clk;

    consist_resolver u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model of a resolve: follows links, counts hops, flags loops and free targets.
    task automatic m_resolve(input int s, output bit e, output int sp,
                             output bit d, output int st, output int h);
        int cur = s;
        h = 0; e = 0;
        while (m_up[cur]) begin
            if (h == 128) begin e = 1; break; end
            if (m_st[m_spd[cur]] == 0) begin e = 1; break; end
            cur = m_spd[cur];
            h++;
        end
        sp = e ? 0 : m_spd[cur];
        d  = e ? 0 : m_dir[cur];
        st = e ? 0 : m_st[cur];
    endtask

    // Issue one request, update the model, and compare the response on every cycle.
    task automatic do_req(input int op, input int slot, input int arg,
                          input int spd, input bit dir, input int st,
                          input string req, input bit poke = 0);
        bit e_err, e_dir; int e_spd, e_st, h, lat, n;
        e_err = 0; e_spd = 0; e_dir = 0; e_st = 0; h = 0;
        case (op)
            0: m_resolve(slot, e_err, e_spd, e_dir, e_st, h);
            1: begin
                e_err = m_up[slot];
                if (!e_err) begin m_spd[slot] = spd; m_dir[slot] = dir; m_st[slot] = st; end
            end
            2: begin
                e_err = m_up[slot] || slot == arg || m_st[arg] == 0;
                if (!e_err) begin m_spd[slot] = arg; m_up[slot] = 1; m_dn[arg] = 1; end
            end
            default: begin
                e_err = !m_up[slot];
                if (!e_err) begin m_dn[m_spd[slot]] = 0; m_up[slot] = 0; m_spd[slot] = 0; end
            end
        endcase
        lat = (op == 0) ? h + 2 : 1;
        @(negedge clk);
        req_op = 2'(op); req_slot = 7'(slot); req_arg = 7'(arg);
        req_spd = 7'(spd); req_dir = dir; req_state = 2'(st); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!rsp_valid && n < 400) begin
            if (!busy) chk(0, "R5", "busy before response", 0, 1);
            if (poke && n == 3) begin
                req_op = 2'd1; req_slot = 7'd50; req_spd = 7'h33;
                req_dir = 1'b1; req_state = 2'd3; req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(rsp_valid, req, "response timeout", n, lat);
        chk(n == lat, (op == 0) ? "R3" : "R5", "latency", n, lat);
        chk(!busy, "R5", "busy at response", busy, 0);
        chk(rsp_err == e_err, req, "err", rsp_err, e_err);
        chk(rsp_spd == 7'(e_spd) && rsp_dir == e_dir && rsp_state == 2'(e_st),
            e_err ? "R11" : req, "spd/dir/state",
            {rsp_spd, rsp_dir, rsp_state}, {7'(e_spd), e_dir, 2'(e_st)});
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            m_spd[i] = 0; m_dir[i] = 0; m_up[i] = 0; m_dn[i] = 0; m_st[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs and free table after reset.
        chk(!busy && !rsp_valid, "R1", "idle outputs", {busy, rsp_valid}, 0);
        do_req(0, 5, 0, 0, 0, 0, "R1");
        do_req(0, 127, 0, 0, 0, 0, "R1");
        // R6/R3: store and read back, including the stop and emergency codes.
        do_req(1, 10, 0, 'h40, 1, 3, "R6");
        do_req(0, 10, 0, 0, 0, 0, "R3");
        do_req(1, 11, 0, 'h01, 0, 2, "R6");
        do_req(0, 11, 0, 0, 0, 0, "R3");
        do_req(1, 12, 0, 'h00, 0, 1, "R6");
        do_req(1, 0, 0, 'h7F, 1, 1, "R6");
        do_req(0, 0, 0, 0, 0, 0, "R3");
        // R7/R4: link chain 12 -> 11 -> 10.
        do_req(2, 11, 10, 0, 0, 0, "R7");
        do_req(0, 11, 0, 0, 0, 0, "R4");
        do_req(2, 12, 11, 0, 0, 0, "R7");
        do_req(0, 12, 0, 0, 0, 0, "R4");
        // R7 refusals.
        do_req(2, 12, 10, 0, 0, 0, "R7");
        do_req(1, 13, 0, 'h22, 0, 3, "R6");
        do_req(2, 13, 13, 0, 0, 0, "R7");
        do_req(2, 13, 20, 0, 0, 0, "R7");
        do_req(0, 13, 0, 0, 0, 0, "R7");
        // R6: store to an up-linked slot is refused.
        do_req(1, 11, 0, 'h55, 1, 1, "R6");
        do_req(0, 11, 0, 0, 0, 0, "R6");
        // R8: unlink and double unlink.
        do_req(3, 12, 0, 0, 0, 0, "R8");
        do_req(0, 12, 0, 0, 0, 0, "R8");
        do_req(3, 12, 0, 0, 0, 0, "R8");
        // R9: a closed loop 30 <-> 31; R2: a request presented while busy is ignored.
        do_req(1, 30, 0, 'h10, 0, 3, "R6");
        do_req(1, 31, 0, 'h11, 1, 3, "R6");
        do_req(2, 30, 31, 0, 0, 0, "R7");
        do_req(2, 31, 30, 0, 0, 0, "R7");
        do_req(0, 30, 0, 0, 0, 0, "R9", 1);
        do_req(0, 50, 0, 0, 0, 0, "R2");
        // R10: pointer into a slot that has been freed.
        do_req(1, 40, 0, 'h30, 1, 3, "R6");
        do_req(1, 41, 0, 'h02, 0, 2, "R6");
        do_req(2, 41, 40, 0, 0, 0, "R7");
        do_req(0, 41, 0, 0, 0, 0, "R4");
        do_req(1, 40, 0, 0, 0, 0, "R6");
        do_req(0, 41, 0, 0, 0, 0, "R10");
        // R4: deep chain 100 -> 101 -> ... -> 119.
        for (int i = 100; i < 120; i++) do_req(1, i, 0, i - 90, i % 2, 3, "R6");
        for (int i = 100; i < 119; i++) do_req(2, i, i + 1, 0, 0, 0, "R7");
        do_req(0, 100, 0, 0, 0, 0, "R4");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule